// File: doc/BRIEF.md
# Hex record stream parser

The parser takes a stream of ASCII characters, one on each clock beat that has the valid strobe high, and decodes hexadecimal object-file records from it. A colon starts a record. The colon is followed by pairs of hex digits, in this order:

- a one-byte count;
- the load address, high byte first;
- a one-byte type;
- count data bytes;
- a one-byte checksum.

The parser emits each data byte as soon as its second digit arrives, together with the address that byte belongs at. When the record ends, the parser reports one of two outcomes. If the checksum is correct it pulses record-done. If the checksum is wrong, or the record was broken off, it pulses checksum-error.

Data bytes leave the block before the checksum has been checked. Downstream logic can hold them until record-done arrives and drop them on checksum-error. A record with a count of zero closes the file. For that record the parser pulses end-of-file and presents the address field as the execution start address. Any character outside a record is ignored, so a noisy or line-delimited stream locks back on at the next colon.

Top module: `hexrec_parser`

## Requirements
- R1: After reset every output is zero. Characters that arrive before the first colon produce no output.
- R2: Hex digits 0-9, A-F and a-f are all accepted, with the high nibble first. After the colon the fields are: count (1 byte), address (ADDR_BYTES bytes, most significant first), type (1 byte), count data bytes, and checksum (1 byte).
- R3: Each data byte appears on byte_out, with byte_valid high for one cycle, in the cycle after the beat that carries its second digit. addr_out is the record address plus the byte's index within the record, modulo 2^(8*ADDR_BYTES).
- R4: When the sum modulo 256 of every byte after the colon, including the checksum, is zero, rec_done pulses for one cycle in the cycle after the checksum's second digit.
- R5: When that sum is not zero, cksum_err pulses in place of rec_done. The record's data bytes are still emitted.
- R6: A record whose count is zero and whose checksum is correct pulses eof together with rec_done. In the same cycle start_addr takes the record's address field.
- R7: The type byte enters the checksum and has no other effect. A record of type 05 yields the same data bytes and addresses as one of type 00.
- R8: A character that is neither a colon nor a hex digit, arriving inside a record, pulses cksum_err in the next cycle. Everything after it up to the next colon is ignored.
- R9: Characters that follow a record's checksum are ignored until the next colon.
- R10: A colon that arrives inside an unfinished record pulses cksum_err and starts a new record.
- R11: Every count from 0 to 255 is accepted. A record of 255 data bytes emits all 255 of them.
- R12: A cycle with char_valid low has no effect: it produces no output and does not advance the parse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_in | input | 8 | ASCII character |
| char_valid | input | 1 | char_in holds a character this cycle |
| byte_out | output | 8 | Decoded data byte |
| addr_out | output | 8*ADDR_BYTES | Target address of byte_out |
| byte_valid | output | 1 | byte_out and addr_out are valid |
| rec_done | output | 1 | Record finished with a correct checksum |
| cksum_err | output | 1 | Record was corrupt or broken off |
| eof | output | 1 | End-of-file record received |
| start_addr | output | 8*ADDR_BYTES | Execution start address from the last end-of-file record |

## Verification
The bench builds the block with the default ADDR_BYTES of 2, which matches the two-byte address field of the format. With that width the address can wrap from FFFF to 0000 inside a single record, and the bench exercises exactly that case. The count field is fixed at one byte, so a 255-byte record reaches the largest count and the deepest index compare.

// File: rtl/hexrec_parser.sv
module hexrec_parser #(
  parameter int ADDR_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              char_in,
  input  logic                    char_valid,
  output logic [7:0]              byte_out,
  output logic [8*ADDR_BYTES-1:0] addr_out,
  output logic                    byte_valid,
  output logic                    rec_done,
  output logic                    cksum_err,
  output logic                    eof,
  output logic [8*ADDR_BYTES-1:0] start_addr
);
  localparam int AW = 8 * ADDR_BYTES;

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_ADDR, S_TYPE, S_DATA, S_SUM} st_t;
  st_t        st;
  logic       have_hi;
  logic [3:0] hi, nib;
  logic       is_hex;
  logic [7:0] sum, cnt, idx;
  logic [AW-1:0] base;

  always_comb begin
    is_hex = 1'b1;
    nib    = 4'h0;
    if (char_in >= 8'h30 && char_in <= 8'h39)      nib = 4'(char_in - 8'h30);
    else if (char_in >= 8'h41 && char_in <= 8'h46) nib = 4'(char_in - 8'h37);
    else if (char_in >= 8'h61 && char_in <= 8'h66) nib = 4'(char_in - 8'h57);
    else                                           is_hex = 1'b0;
  end

  wire       colon = (char_in == 8'h3A);
  wire [7:0] b     = {hi, nib};
  wire [7:0] sum_n = sum + b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; have_hi <= 1'b0; hi <= '0; sum <= '0; cnt <= '0; idx <= '0;
      base <= '0; byte_out <= '0; addr_out <= '0; start_addr <= '0;
      byte_valid <= 1'b0; rec_done <= 1'b0; cksum_err <= 1'b0; eof <= 1'b0;
    end else begin
      byte_valid <= 1'b0; rec_done <= 1'b0; cksum_err <= 1'b0; eof <= 1'b0;
      if (char_valid) begin
        if (colon) begin
          if (st != S_IDLE) cksum_err <= 1'b1;
          st <= S_CNT; have_hi <= 1'b0; sum <= '0;
        end else if (st != S_IDLE) begin
          if (!is_hex) begin
            cksum_err <= 1'b1;
            st <= S_IDLE;
          end else if (!have_hi) begin
            hi <= nib; have_hi <= 1'b1;
          end else begin
            have_hi <= 1'b0;
            sum <= sum_n;
            case (st)
              S_CNT: begin cnt <= b; idx <= '0; st <= S_ADDR; end
              S_ADDR: begin
                base <= (base << 8) | AW'(b);
                if (idx == 8'(ADDR_BYTES - 1)) begin idx <= '0; st <= S_TYPE; end
                else idx <= idx + 8'd1;
              end
              S_TYPE: begin idx <= '0; st <= (cnt == 8'd0) ? S_SUM : S_DATA; end
              S_DATA: begin
                byte_out <= b; addr_out <= base + AW'(idx); byte_valid <= 1'b1;
                idx <= idx + 8'd1;
                if (idx == cnt - 8'd1) st <= S_SUM;
              end
              S_SUM: begin
                st <= S_IDLE;
                if (sum_n == 8'd0) begin
                  rec_done <= 1'b1;
                  if (cnt == 8'd0) begin eof <= 1'b1; start_addr <= base; end
                end else cksum_err <= 1'b1;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  p_outcome_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) !(rec_done && cksum_err));
  p_eof_good_r6: assert property (@(posedge clk) disable iff (!rst_n) eof |-> rec_done);
  p_byte_not_done_r3: assert property (@(posedge clk) disable iff (!rst_n) !(byte_valid && rec_done));
  p_idle_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |=> !(byte_valid || rec_done || cksum_err || eof));
  p_start_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eof |=> $stable(start_addr) || eof);
endmodule

// File: tb/test_hexrec_parser.sv
module test_hexrec_parser;
  logic clk = 0, rst_n = 0, char_valid = 0;
  logic [7:0] char_in = 8'h20;
  logic [7:0] byte_out;
  logic [15:0] addr_out, start_addr;
  logic byte_valid, rec_done, cksum_err, eof;

  hexrec_parser i_hexrec_parser (.clk(clk), .rst_n(rst_n), .char_in(char_in), .char_valid(char_valid),
    .byte_out(byte_out), .addr_out(addr_out), .byte_valid(byte_valid), .rec_done(rec_done),
    .cksum_err(cksum_err), .eof(eof), .start_addr(start_addr));

  always #5 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit finished = 0;
  int n_bytes = 0, n_done = 0, n_err = 0, n_eof = 0;
  logic [7:0]  got_b [0:511];
  logic [15:0] got_a [0:511];
  logic [7:0]  pay [0:255];

  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin got_b[n_bytes % 512] = byte_out; got_a[n_bytes % 512] = addr_out; n_bytes++; end
    if (rec_done) n_done++;
    if (cksum_err) n_err++;
    if (eof) n_eof++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin nfail++; $display("FAIL %s: actual %0h expected %0h", tag, act, exp); end
  endtask

  task automatic send_char(input logic [7:0] c, input int gap = 0);
    @(negedge clk); char_in = c; char_valid = 1;
    @(posedge clk); #1 char_valid = 0;
    repeat (gap) @(posedge clk);
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
    if (n < 10) return 8'h30 + 8'(n);
    return (lower ? 8'h57 : 8'h37) + 8'(n);
  endfunction

  task automatic send_byte(input logic [7:0] v, input bit lower, input int gap);
    send_char(hexc(v[7:4], lower), gap);
    send_char(hexc(v[3:0], lower), gap);
  endtask

  task automatic send_rec(input int cnt, input logic [15:0] a, input logic [7:0] typ,
                          input bit bad, input bit lower, input int gap = 0);
    logic [7:0] s;
    s = 8'(cnt) + a[15:8] + a[7:0] + typ;
    send_char(8'h3A, gap);
    send_byte(8'(cnt), lower, gap); send_byte(a[15:8], lower, gap);
    send_byte(a[7:0], lower, gap); send_byte(typ, lower, gap);
    for (int i = 0; i < cnt; i++) begin send_byte(pay[i], lower, gap); s += pay[i]; end
    s = -s;
    if (bad) s ^= 8'h01;
    send_byte(s, lower, gap);
  endtask

  task automatic settle; repeat (3) @(negedge clk); endtask

  task automatic check_bytes(input int b0, input int cnt, input logic [15:0] a, input string tag);
    chk(n_bytes - b0 == cnt, tag, n_bytes - b0, cnt);
    for (int i = 0; i < cnt && i < 8; i++) begin
      chk(got_b[(b0+i)%512] == pay[i], tag, got_b[(b0+i)%512], pay[i]);
      chk(got_a[(b0+i)%512] == 16'(a + 16'(i)), tag, got_a[(b0+i)%512], 16'(a + 16'(i)));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({byte_valid, rec_done, cksum_err, eof} == 0, "R1 reset pulses", {byte_valid, rec_done, cksum_err, eof}, 0);
    chk(start_addr == 0 && addr_out == 0 && byte_out == 0, "R1 reset values", start_addr, 0);
  endtask

  task automatic t_garbage;
    int b0 = n_bytes, d0 = n_done, e0 = n_err;
    send_char("x"); send_char("1"); send_char("2"); send_char("A"); send_char("B"); send_char("G");
    settle;
    chk(n_bytes == b0 && n_done == d0 && n_err == e0, "R1 pre-colon ignored", n_bytes - b0, 0);
  endtask

  task automatic t_basic;
    int b0 = n_bytes, d0 = n_done, e0 = n_err;
    pay[0] = 8'h11; pay[1] = 8'hA5; pay[2] = 8'h00; pay[3] = 8'hFE;
    send_rec(4, 16'h1230, 8'h00, 0, 0);
    @(negedge clk);
    chk(rec_done == 1, "R4 done timing", rec_done, 1);
    settle;
    check_bytes(b0, 4, 16'h1230, "R3 data/addr");
    chk(n_done - d0 == 1 && n_err == e0, "R4 good checksum", n_done - d0, 1);
  endtask

  task automatic t_lower_type;
    int b0 = n_bytes, d0 = n_done;
    pay[0] = 8'hBC; pay[1] = 8'hDE; pay[2] = 8'hAF;
    send_rec(3, 16'hABCD, 8'h05, 0, 1);
    settle;
    check_bytes(b0, 3, 16'hABCD, "R7 R2 lowercase type05");
    chk(n_done - d0 == 1, "R7 type05 done", n_done - d0, 1);
  endtask

  task automatic t_wrap;
    int b0 = n_bytes;
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'h40 + i);
    send_rec(4, 16'hFFFE, 8'h00, 0, 0);
    settle;
    check_bytes(b0, 4, 16'hFFFE, "R3 wrap");
    chk(got_a[(b0+2)%512] == 16'h0000, "R3 wrap to zero", got_a[(b0+2)%512], 0);
  endtask

  task automatic t_bad;
    int b0 = n_bytes, d0 = n_done, e0 = n_err;
    pay[0] = 8'h77; pay[1] = 8'h88;
    send_rec(2, 16'h0100, 8'h00, 1, 0);
    @(negedge clk);
    chk(cksum_err == 1, "R5 err timing", cksum_err, 1);
    settle;
    chk(n_err - e0 == 1 && n_done == d0, "R5 bad checksum", n_err - e0, 1);
    chk(n_bytes - b0 == 2, "R5 bytes still emitted", n_bytes - b0, 2);
  endtask

  task automatic t_eof;
    int e0 = n_eof, d0 = n_done;
    send_rec(0, 16'h4567, 8'h01, 0, 0);
    @(negedge clk);
    chk(eof == 1 && rec_done == 1, "R6 eof pulse", {eof, rec_done}, 3);
    chk(start_addr == 16'h4567, "R6 start addr", start_addr, 16'h4567);
    settle;
    chk(n_eof - e0 == 1 && n_done - d0 == 1, "R6 eof count", n_eof - e0, 1);
  endtask

  task automatic t_nonhex;
    int b0 = n_bytes, d0 = n_done, e0 = n_err;
    send_char(":"); send_char("0"); send_char("2"); send_char("1"); send_char("G");
    @(negedge clk);
    chk(cksum_err == 1, "R8 non-hex err", cksum_err, 1);
    send_char("2"); send_char("0"); send_char("0"); send_char("0");
    send_char("A"); send_char("B"); send_char("C"); send_char("D"); send_char("0"); send_char("0");
    settle;
    chk(n_bytes == b0 && n_done == d0 && n_err - e0 == 1, "R8 rest ignored", n_bytes - b0, 0);
  endtask

  task automatic t_trailing;
    int b0, d0, e0;
    pay[0] = 8'h5A;
    send_rec(1, 16'h2000, 8'h00, 0, 0);
    settle;
    b0 = n_bytes; d0 = n_done; e0 = n_err;
    for (int i = 0; i < 12; i++) send_char(hexc(4'(i), 0));
    settle;
    chk(n_bytes == b0 && n_done == d0 && n_err == e0, "R9 trailing ignored", n_bytes - b0, 0);
  endtask

  task automatic t_colon_mid;
    int b0, d0 = n_done, e0 = n_err;
    send_char(":"); send_char("0"); send_char("4"); send_char("1"); send_char("2");
    b0 = n_bytes;
    pay[0] = 8'h99; pay[1] = 8'h66;
    send_rec(2, 16'h3000, 8'h00, 0, 0);
    settle;
    chk(n_err - e0 == 1, "R10 mid colon err", n_err - e0, 1);
    chk(n_done - d0 == 1, "R10 new record done", n_done - d0, 1);
    check_bytes(b0, 2, 16'h3000, "R10 new record data");
  endtask

  task automatic t_long;
    int b0 = n_bytes, d0 = n_done;
    for (int i = 0; i < 255; i++) pay[i] = 8'(i * 7 + 3);
    send_rec(255, 16'h8000, 8'h00, 0, 0);
    settle;
    check_bytes(b0, 255, 16'h8000, "R11 long record");
    chk(got_a[(b0+254)%512] == 16'h80FE, "R11 last addr", got_a[(b0+254)%512], 16'h80FE);
    chk(got_b[(b0+254)%512] == pay[254], "R11 last byte", got_b[(b0+254)%512], pay[254]);
    chk(n_done - d0 == 1, "R11 done", n_done - d0, 1);
  endtask

  task automatic t_gaps;
    int b0 = n_bytes, d0 = n_done, e0 = n_err;
    pay[0] = 8'hC3; pay[1] = 8'h3C;
    @(negedge clk); char_in = 8'h3A;
    repeat (2) @(negedge clk);
    chk(n_err == e0 && byte_valid == 0, "R12 invalid colon no effect", n_err - e0, 0);
    send_rec(2, 16'h0042, 8'h00, 0, 1, 3);
    settle;
    check_bytes(b0, 2, 16'h0042, "R12 gapped stream");
    chk(n_done - d0 == 1 && n_err == e0, "R12 gapped done", n_done - d0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_garbage; t_basic; t_lower_type; t_wrap; t_bad; t_eof;
    t_nonhex; t_trailing; t_colon_mid; t_long; t_gaps;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      nvec++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule